// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock of an I2C master. It keeps four count registers: a high count and a low count for standard mode, and another pair for fast mode. A speed-select input chooses the pair. Once the block is enabled and a start request arrives, it runs a continuous clock train. Each low phase asks the pad to pull SCL down. Each high phase releases the line. The bit engine that shifts data gets two one-cycle strobes: one near the middle of the high phase for sampling SDA, and one on the final cycle of the low phase for changing SDA.

The programmed counts are not the real periods. The low-phase counter starts on the same clock that SCL is pulled low, so the low count has to cover the fall time as well, and the phase lasts one clock more than the count. The high phase carries a fixed overhead of eight clocks on top of its count. The high counter does not start until the sampled SCL line reads high. A slave that holds SCL low therefore stretches the clock without eating into the high time. Counts below a floor are raised to that floor. The count registers accept writes only while the block is disabled.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, and on every cycle that follows a clock edge at which `enable` is 0, `scl_drive_low`, `sample_stb` and `change_stb` are all 0. Dropping `enable` in the middle of a phase ends the clock train on the next cycle.
- R2: A clock edge that sees `enable` = 1 and `start_req` = 1 while the block is idle starts a low phase, and `scl_drive_low` is 1 in the following cycle. A `start_req` that arrives while the train is running has no effect on any phase length.
- R3: Each low phase holds `scl_drive_low` at 1 for exactly (low count + 1) consecutive cycles.
- R4: Each high phase holds `scl_drive_low` at 0 for S + (high count + 8) cycles. S is the number of released cycles at whose closing edge `scl_in` was still 0 before the count began.
- R5: With `fast_sel` = 0 the standard-mode pair is used, and with `fast_sel` = 1 the fast-mode pair is used. `fast_sel` is sampled only at the edge that begins a low phase, and that choice holds for the low phase and the high phase that follows it.
- R6: A low count below 6 behaves as 6, giving 7 low cycles. A high count below 8 behaves as 8, giving 16 high cycles before any stretch.
- R7: A write is taken when `cnt_wr_en` = 1 at a clock edge and `enable` = 0. `cnt_wr_addr` selects the register: 0 is standard high, 1 is standard low, 2 is fast high and 3 is fast low. A write attempted while `enable` = 1 is ignored.
- R8: `change_stb` pulses once per low phase, on its final cycle, while `scl_drive_low` is still 1.
- R9: `sample_stb` pulses once per high phase. With the cycles numbered from 0 at the first counted high cycle and H the effective high length, the pulse falls on index (H-1) - floor((H-1)/2).
- R10: Once the high count has begun, `scl_in` going low again does not change the length of that high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; 0 idles the block and unlocks the count registers |
| fast_sel | input | 1 | 0 selects the standard-mode counts, 1 selects the fast-mode counts |
| start_req | input | 1 | Begins the clock train from idle |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_addr | input | 2 | Count register select (0 std high, 1 std low, 2 fast high, 3 fast low) |
| cnt_wr_data | input | CNT_W | Count value to write |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| sample_stb | output | 1 | One-cycle strobe near mid high phase (sample SDA) |
| change_stb | output | 1 | One-cycle strobe on the last low cycle (change SDA) |

## Verification
The hardest case to produce is a slave stretch that lines up exactly with the release, together with a line that drops again after the high count has started. Both depend on `scl_in` timing relative to an internal count that the ports do not show. The bench models the open-drain line as the AND of the block's release and a slave hold signal. It lifts the hold at a chosen released-cycle index, and for the second case it pulls the line low again for two cycles a few counts into the high phase. The measured high length then shows whether the stall cycles were added and whether the later dip was ignored.

// File: rtl/scl_pgen_pkg.sv
package scl_pgen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;

   localparam logic [1:0] SEL_STD_HIGH  = 2'd0;
   localparam logic [1:0] SEL_STD_LOW   = 2'd1;
   localparam logic [1:0] SEL_FAST_HIGH = 2'd2;
   localparam logic [1:0] SEL_FAST_LOW  = 2'd3;

endpackage

// File: rtl/scl_cnt_bank.sv
module scl_cnt_bank
   import scl_pgen_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int RST_STD_H  = 40,
   parameter int RST_STD_L  = 47,
   parameter int RST_FAST_H = 6,
   parameter int RST_FAST_L = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] std_h,
   output logic [CNT_W-1:0] std_l,
   output logic [CNT_W-1:0] fast_h,
   output logic [CNT_W-1:0] fast_l
);

   logic wr_ok;
   assign wr_ok = wr_en && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         std_h  <= CNT_W'(RST_STD_H);
         std_l  <= CNT_W'(RST_STD_L);
         fast_h <= CNT_W'(RST_FAST_H);
         fast_l <= CNT_W'(RST_FAST_L);
      end else if (wr_ok) begin
         case (wr_addr)
            SEL_STD_HIGH:  std_h  <= wr_data;
            SEL_STD_LOW:   std_l  <= wr_data;
            SEL_FAST_HIGH: fast_h <= wr_data;
            default:       fast_l <= wr_data;
         endcase
      end
   end

endmodule

// File: rtl/scl_period_sel.sv
module scl_period_sel #(
   parameter int CNT_W    = 16,
   parameter int PER_W    = 20,
   parameter int MIN_LOW  = 6,
   parameter int MIN_HIGH = 8,
   parameter int LOW_OVH  = 1,
   parameter int HIGH_OVH = 8,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic             fast_sel,
   input  logic [CNT_W-1:0] std_h,
   input  logic [CNT_W-1:0] std_l,
   input  logic [CNT_W-1:0] fast_h,
   input  logic [CNT_W-1:0] fast_l,
   output logic [PER_W-1:0] l_eff,
   output logic [PER_W-1:0] h_eff
);

   logic [PER_W-1:0] l_raw, h_raw;
   logic [PER_W-1:0] l_cl, h_cl;

   assign l_raw = PER_W'(fast_sel ? fast_l : std_l);
   assign h_raw = PER_W'(fast_sel ? fast_h : std_h);

   generate
      if (CLAMP_EN) begin : g_clamp
         always_comb begin
            l_cl = (l_raw < PER_W'(MIN_LOW))  ? PER_W'(MIN_LOW)  : l_raw;
            h_cl = (h_raw < PER_W'(MIN_HIGH)) ? PER_W'(MIN_HIGH) : h_raw;
         end
      end else begin : g_raw
         assign l_cl = l_raw;
         assign h_cl = h_raw;
      end
   endgenerate

   assign l_eff = l_cl + PER_W'(LOW_OVH);
   assign h_eff = h_cl + PER_W'(HIGH_OVH);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_pgen_pkg::*;
#(
   parameter int PER_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start_req,
   input  logic             scl_in,
   input  logic [PER_W-1:0] l_eff,
   input  logic [PER_W-1:0] h_eff,
   output logic             scl_drive_low,
   output logic             sample_stb,
   output logic             change_stb
);

   scl_phase_e       phase_q;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] hper_q;
   logic [PER_W-1:0] mid_q;
   logic             started_q;
   logic             hi_counting;
   logic             cnt_zero;

   assign cnt_zero    = (cnt_q == '0);
   assign hi_counting = (phase_q == PH_HIGH) && (started_q || scl_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         hper_q    <= '0;
         mid_q     <= '0;
         started_q <= 1'b0;
      end else if (!enable) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         hper_q    <= '0;
         mid_q     <= '0;
         started_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start_req) begin
                  phase_q <= PH_LOW;
                  cnt_q   <= l_eff - 1'b1;
                  hper_q  <= h_eff;
               end
            end
            PH_LOW: begin
               if (cnt_zero) begin
                  phase_q   <= PH_HIGH;
                  cnt_q     <= hper_q - 1'b1;
                  mid_q     <= (hper_q - 1'b1) >> 1;
                  started_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HIGH: begin
               if (hi_counting) begin
                  started_q <= 1'b1;
                  if (cnt_zero) begin
                     phase_q <= PH_LOW;
                     cnt_q   <= l_eff - 1'b1;
                     hper_q  <= h_eff;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign scl_drive_low = (phase_q == PH_LOW);
   assign change_stb    = (phase_q == PH_LOW) && cnt_zero;
   assign sample_stb    = hi_counting && (cnt_q == mid_q);

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
   parameter int CNT_W      = 16,
   parameter int MIN_LOW    = 6,
   parameter int MIN_HIGH   = 8,
   parameter int LOW_OVH    = 1,
   parameter int HIGH_OVH   = 8,
   parameter bit CLAMP_EN   = 1'b1,
   parameter int RST_STD_H  = 40,
   parameter int RST_STD_L  = 47,
   parameter int RST_FAST_H = 6,
   parameter int RST_FAST_L = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             fast_sel,
   input  logic             start_req,
   input  logic             cnt_wr_en,
   input  logic [1:0]       cnt_wr_addr,
   input  logic [CNT_W-1:0] cnt_wr_data,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             sample_stb,
   output logic             change_stb
);

   localparam int PER_W = CNT_W + 4;

   generate
      if (CNT_W < 4 || CNT_W > 24) begin : g_bad_width
         $error("scl_period_gen: CNT_W out of range 4..24");
      end
      if (LOW_OVH < 1 || HIGH_OVH < 1 || HIGH_OVH > 15) begin : g_bad_ovh
         $error("scl_period_gen: overhead values out of range");
      end
      if (MIN_LOW < 0 || MIN_HIGH < 0 || MIN_LOW >= (1 << CNT_W) || MIN_HIGH >= (1 << CNT_W)) begin : g_bad_min
         $error("scl_period_gen: minimum counts do not fit CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] std_h, std_l, fast_h, fast_l;
   logic [PER_W-1:0] l_eff, h_eff;

   scl_cnt_bank #(
      .CNT_W      (CNT_W),
      .RST_STD_H  (RST_STD_H),
      .RST_STD_L  (RST_STD_L),
      .RST_FAST_H (RST_FAST_H),
      .RST_FAST_L (RST_FAST_L)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock    (enable),
      .wr_en   (cnt_wr_en),
      .wr_addr (cnt_wr_addr),
      .wr_data (cnt_wr_data),
      .std_h   (std_h),
      .std_l   (std_l),
      .fast_h  (fast_h),
      .fast_l  (fast_l)
   );

   scl_period_sel #(
      .CNT_W    (CNT_W),
      .PER_W    (PER_W),
      .MIN_LOW  (MIN_LOW),
      .MIN_HIGH (MIN_HIGH),
      .LOW_OVH  (LOW_OVH),
      .HIGH_OVH (HIGH_OVH),
      .CLAMP_EN (CLAMP_EN)
   ) u_sel (
      .fast_sel (fast_sel),
      .std_h    (std_h),
      .std_l    (std_l),
      .fast_h   (fast_h),
      .fast_l   (fast_l),
      .l_eff    (l_eff),
      .h_eff    (h_eff)
   );

   scl_phase_fsm #(
      .PER_W (PER_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .start_req     (start_req),
      .scl_in        (scl_in),
      .l_eff         (l_eff),
      .h_eff         (h_eff),
      .scl_drive_low (scl_drive_low),
      .sample_stb    (sample_stb),
      .change_stb    (change_stb)
   );

endmodule

// File: rtl/scl_pgen_chk.sv
module scl_pgen_chk #(
   parameter int MIN_LOW  = 6,
   parameter int LOW_OVH  = 1,
   parameter bit CLAMP_EN = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_in,
   input logic scl_drive_low,
   input logic sample_stb,
   input logic change_stb
);

   int unsigned low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_run <= 0;
      else if (scl_drive_low) low_run <= low_run + 1;
      else low_run <= 0;
   end

   // R1: a disabled edge leaves the line released and strobes quiet
   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_drive_low && !sample_stb && !change_stb));

   // R8: change strobe sits on the last low cycle
   assert_change_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      change_stb |-> scl_drive_low);
   assert_change_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      change_stb |=> !scl_drive_low);

   // R9: sample strobe only while SCL is released
   assert_sample_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !scl_drive_low);

   // R4: a held-low line right after release keeps the high phase going
   assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_drive_low) && !scl_in) |=> !scl_drive_low);

   // R6: a completed low phase is never shorter than the floor
   generate
      if (CLAMP_EN) begin : g_min
         assert_low_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(scl_drive_low) && $past(enable)) |-> (low_run >= (MIN_LOW + LOW_OVH)));
      end
   endgenerate

endmodule

bind scl_period_gen scl_pgen_chk #(
   .MIN_LOW  (MIN_LOW),
   .LOW_OVH  (LOW_OVH),
   .CLAMP_EN (CLAMP_EN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .scl_in        (scl_in),
   .scl_drive_low (scl_drive_low),
   .sample_stb    (sample_stb),
   .change_stb    (change_stb)
);

// File: tb/scl_period_gen_tb_top.sv
module scl_period_gen_tb_top;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             fast_sel = 1'b0;
   logic             start_req = 1'b0;
   logic             cnt_wr_en = 1'b0;
   logic [1:0]       cnt_wr_addr = 2'd0;
   logic [CNT_W-1:0] cnt_wr_data = '0;
   logic             slave_hold = 1'b0;
   logic             scl_in;
   logic             scl_drive_low, sample_stb, change_stb;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign scl_in = !scl_drive_low && !slave_hold;

   scl_period_gen #(.CNT_W(CNT_W)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .fast_sel      (fast_sel),
      .start_req     (start_req),
      .cnt_wr_en     (cnt_wr_en),
      .cnt_wr_addr   (cnt_wr_addr),
      .cnt_wr_data   (cnt_wr_data),
      .scl_in        (scl_in),
      .scl_drive_low (scl_drive_low),
      .sample_stb    (sample_stb),
      .change_stb    (change_stb)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_low(input int raw);
      return ((raw < 6) ? 6 : raw) + 1;
   endfunction

   function automatic int exp_high(input int raw);
      return ((raw < 8) ? 8 : raw) + 8;
   endfunction

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      cnt_wr_en = 1'b1;
      cnt_wr_addr = a;
      cnt_wr_data = CNT_W'(d);
      @(negedge clk);
      cnt_wr_en = 1'b0;
   endtask

   task automatic start_train();
      @(negedge clk);
      enable = 1'b1;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      chk(scl_drive_low == 1'b1, "R2", "drive one cycle after start", int'(scl_drive_low), 1);
   endtask

   task automatic stop_train();
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
   endtask

   task automatic skip_to_low();
      while (scl_drive_low) @(negedge clk);
      while (!scl_drive_low) @(negedge clk);
   endtask

   // measures one low phase followed by one high phase and checks them
   task automatic check_bit(input string tag, input int hold, input int glitch,
                            input bit pulse_st, input int el, input int eh);
      int lo, hi, chg, smp, nchg, nsmp, esmp;
      while (!scl_drive_low) @(negedge clk);
      slave_hold = (hold > 0);
      lo = 0; chg = -1; nchg = 0;
      while (scl_drive_low && lo < 5000) begin
         if (change_stb) begin chg = lo; nchg++; end
         start_req = (pulse_st && lo == 2);
         lo++;
         @(negedge clk);
      end
      start_req = 1'b0;
      hi = 0; smp = -1; nsmp = 0;
      while (!scl_drive_low && hi < 5000) begin
         if (sample_stb) begin smp = hi - hold; nsmp++; end
         if (hi == hold) slave_hold = 1'b0;
         if (glitch >= 0 && hi == hold + glitch) slave_hold = 1'b1;
         if (glitch >= 0 && hi == hold + glitch + 2) slave_hold = 1'b0;
         hi++;
         @(negedge clk);
      end
      slave_hold = 1'b0;
      esmp = (eh - 1) - ((eh - 1) >> 1);
      chk(lo == el, tag, "low length", lo, el);
      chk(hi == hold + eh, tag, "high length", hi, hold + eh);
      chk(nchg == 1 && chg == lo - 1, {tag, " R8"}, "change strobe index", chg, lo - 1);
      chk(nsmp == 1 && smp == esmp, {tag, " R9"}, "sample strobe index", smp, esmp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(scl_drive_low == 1'b0, "R1", "reset drive", int'(scl_drive_low), 0);
      chk(!sample_stb && !change_stb, "R1", "reset strobes",
          int'({sample_stb, change_stb}), 0);
   endtask

   task automatic t_nominal();
      wr(2'd0, 20); wr(2'd1, 12); wr(2'd2, 10); wr(2'd3, 7);
      fast_sel = 1'b0;
      start_train();
      check_bit("R3 R4 R7 std", 0, -1, 1'b0, exp_low(12), exp_high(20));
      check_bit("R3 R4 std repeat", 0, -1, 1'b0, exp_low(12), exp_high(20));
   endtask

   task automatic t_speed();
      fast_sel = 1'b1;   // current bit already latched standard
      check_bit("R5 latched std", 0, -1, 1'b0, exp_low(12), exp_high(20));
      fast_sel = 1'b0;   // current bit already latched fast
      check_bit("R5 fast pair", 0, -1, 1'b0, exp_low(7), exp_high(10));
      check_bit("R5 back to std", 0, -1, 1'b0, exp_low(12), exp_high(20));
   endtask

   task automatic t_stretch();
      check_bit("R4 stretch", 5, -1, 1'b0, exp_low(12), exp_high(20));
      check_bit("R10 late dip", 0, 3, 1'b0, exp_low(12), exp_high(20));
   endtask

   task automatic t_start_ignored();
      check_bit("R2 start while running", 0, -1, 1'b1, exp_low(12), exp_high(20));
   endtask

   task automatic t_locked_write();
      wr(2'd1, 30);
      skip_to_low();
      check_bit("R7 locked write", 0, -1, 1'b0, exp_low(12), exp_high(20));
      // drop enable in the middle of a low phase
      repeat (2) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(scl_drive_low == 1'b0, "R1", "drive after disable", int'(scl_drive_low), 0);
      repeat (3) begin
         @(negedge clk);
         chk(!scl_drive_low && !sample_stb && !change_stb, "R1", "quiet while disabled",
             int'({scl_drive_low, sample_stb, change_stb}), 0);
      end
      wr(2'd1, 30);
      start_train();
      check_bit("R7 unlocked write", 0, -1, 1'b0, exp_low(30), exp_high(20));
      stop_train();
   endtask

   task automatic t_clamp();
      wr(2'd0, 3); wr(2'd1, 2);
      start_train();
      check_bit("R6 clamp", 0, -1, 1'b0, exp_low(2), exp_high(3));
      wr(2'd2, 0); wr(2'd3, 0);   // locked: fast pair stays 10/7
      fast_sel = 1'b1;
      skip_to_low();
      check_bit("R6 R7 fast unchanged", 0, -1, 1'b0, exp_low(7), exp_high(10));
      stop_train();
      fast_sel = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_nominal();
      t_speed();
      t_stretch();
      t_start_ignored();
      t_locked_write();
      t_clamp();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

endmodule